// File: doc/BRIEF.md
# Multi-Queue Transmit Scheduler

This block chooses which of up to sixteen circular transmit rings sends next and presents that choice to a set of eight DMA channels. Each ring has two 8-bit indexes into a 256-entry ring. The host sets the producer index, and the scheduler advances the consumer index. A per-ring setup word marks the ring live and binds it to one channel. Any number of rings may share one channel.

A channel-enable input masks whole channels. Channels are ranked, and within a rank the rings take turns by ring number. The block holds one frame request at a time, naming the ring, the index to send and the channel. It keeps that request steady until a grant arrives, then moves the ring's consumer index forward by one.

The host reaches the state through a single write port that selects one of four targets. The setup words and the idle-flag word carry their own per-bit write enables, so the host can change some fields and leave the rest as they are. A combinational read-back port returns one ring's indexes and setup word, together with all idle flags.

Top module: `tx_sched`

## Requirements
- R1: After reset every producer index, consumer index and setup word reads 0, every idle flag reads 1, and `req_valid` is 0.
- R2: A write with `wr_kind`=0 sets the producer index of ring `wr_queue` to `wr_data[7:0]`. The idle flag of that ring becomes 1 if the new value equals the ring's consumer index, and 0 otherwise.
- R3: A write with `wr_kind`=1 sets the consumer index of ring `wr_queue` to `wr_data[7:0]`. The idle flag of that ring becomes 1 if the new value equals the ring's producer index, and 0 otherwise.
- R4: A write with `wr_kind`=2 updates the 10-bit setup word of ring `wr_queue`. Bit k of `wr_data[19:10]` enables the update of bit k from `wr_data[9:0]`, and bits whose enable is 0 keep their value. The word's fields are: bit 0 live, bits 4:1 channel (bits 3:1 select channel 0–7), bit 5 window space, bit 8 acknowledged-window mode.
- R5: A write with `wr_kind`=3 forces idle flags. For each ring i whose bit `wr_data[16+i]` is 1, idle flag i takes `wr_data[i]`, where 1 means idle. Rings whose enable bit is 0 keep their flag.
- R6: A ring is eligible only when it is live, its channel's bit in `chan_en` is 1, and its idle flag is 0. With no eligible ring, no request is raised.
- R7: Channels 4–7 share the highest rank. Below them the order is channel 3, then 2, then 1, then 0. A request always comes from the highest rank that has an eligible ring.
- R8: Within the winning rank, the ring chosen is the first eligible ring after the last granted ring, in increasing ring number and wrapping. After reset, the search starts at ring 0.
- R9: Once raised, a request keeps the same `req_queue`, `req_index` and `req_chan` until granted, even if its channel is disabled in the meantime.
- R10: A grant moves the ring's consumer index forward by 1 modulo 256. It sets the idle flag when the new index equals the producer index, and drops `req_valid` for the next cycle.
- R11: `req_index` equals the ring's consumer index when the request was raised, and `req_chan` equals the ring's channel field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 8 | Per-channel enable, 1 means enabled |
| wr_en | input | 1 | Host write strobe |
| wr_kind | input | 2 | Write target: 0 producer index, 1 consumer index, 2 setup word, 3 idle flags |
| wr_queue | input | 4 | Ring addressed by the write |
| wr_data | input | 32 | Write data |
| rd_queue | input | 4 | Ring selected for read-back |
| rd_wptr | output | 8 | Producer index of `rd_queue` |
| rd_rptr | output | 8 | Consumer index of `rd_queue` |
| rd_cfg | output | 10 | Setup word of `rd_queue` |
| empty_flags | output | 16 | Idle flag of every ring |
| req_valid | output | 1 | Frame request pending |
| req_queue | output | 4 | Ring of the pending request |
| req_index | output | 8 | Ring index of the frame to send |
| req_chan | output | 3 | Channel of the pending request |
| req_grant | input | 1 | Grant for the pending request |

## Verification
The bench checks consumer-index wrap from 255 to 0. A design that did not wrap, or did not set the idle flag at the wrap, would keep requesting from a drained ring. It also checks a full ring, where the producer and consumer indexes are equal but the idle flag has been forced to 0. A design that tested index equality instead of the flag would never serve such a ring, and one that ignored a forced flag of 1 would send stale frames. Random setup writes with partial masks catch any design that writes unmasked bits. Mixed-rank random traffic exposes a wrong rank order or a round-robin that restarts at ring 0. Disabling a channel while its request is pending exposes a request that changes or vanishes before its grant.

// File: rtl/tx_sched.sv
module tx_sched #(
  parameter int NQ  = 16,
  parameter int NCH = 8,
  parameter int PW  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         chan_en,
  input  logic                   wr_en,
  input  logic [1:0]             wr_kind,
  input  logic [$clog2(NQ)-1:0]  wr_queue,
  input  logic [31:0]            wr_data,
  input  logic [$clog2(NQ)-1:0]  rd_queue,
  output logic [PW-1:0]          rd_wptr,
  output logic [PW-1:0]          rd_rptr,
  output logic [9:0]             rd_cfg,
  output logic [NQ-1:0]          empty_flags,
  output logic                   req_valid,
  output logic [$clog2(NQ)-1:0]  req_queue,
  output logic [PW-1:0]          req_index,
  output logic [$clog2(NCH)-1:0] req_chan,
  input  logic                   req_grant
);
  localparam int QW = $clog2(NQ);
  localparam int CW = $clog2(NCH);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] wptr [NQ];
  logic [PW-1:0] rptr [NQ];
  logic [PW-1:0] rp_nxt [NQ];
  logic [9:0]    cfg [NQ];
  logic [NQ-1:0] empty, elig, cand;
  logic [2:0]    tier [NQ];
  logic [CW-1:0] chan [NQ];
  logic [2:0]    best;
  logic          pick_ok;
  logic [QW-1:0] pick, last_q;
  logic          adv;

  assign adv = req_valid & req_grant;

  for (genvar g = 0; g < NQ; g++) begin : g_q
    assign chan[g]   = cfg[g][1 +: CW];
    assign elig[g]   = cfg[g][0] & chan_en[chan[g]] & ~empty[g];
    assign tier[g]   = (chan[g] >= CW'(4)) ? 3'd4 : 3'(chan[g]);
    assign cand[g]   = elig[g] && (tier[g] == best);
    assign rp_nxt[g] = (adv && req_queue == QW'(g)) ? rptr[g] + ONE : rptr[g];
  end

  always_comb begin
    best = 3'd0;
    for (int q = 0; q < NQ; q++)
      if (elig[q] && tier[q] > best) best = tier[q];
  end

  always_comb begin
    int j;
    pick_ok = 1'b0;
    pick    = '0;
    for (int k = 1; k <= NQ; k++) begin
      j = (int'(last_q) + k) % NQ;
      if (!pick_ok && cand[j]) begin
        pick_ok = 1'b1;
        pick    = QW'(j);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < NQ; q++) begin
        wptr[q] <= '0;
        rptr[q] <= '0;
        cfg[q]  <= '0;
      end
      empty     <= '1;
      req_valid <= 1'b0;
      req_queue <= '0;
      req_index <= '0;
      req_chan  <= '0;
      last_q    <= QW'(NQ - 1);
    end else begin
      if (adv) begin
        rptr[req_queue]  <= rp_nxt[req_queue];
        empty[req_queue] <= (rp_nxt[req_queue] == wptr[req_queue]);
        req_valid        <= 1'b0;
        last_q           <= req_queue;
      end else if (!req_valid && pick_ok) begin
        req_valid <= 1'b1;
        req_queue <= pick;
        req_index <= rptr[pick];
        req_chan  <= chan[pick];
      end
      if (wr_en) begin
        case (wr_kind)
          2'd0: begin
            wptr[wr_queue]  <= wr_data[PW-1:0];
            empty[wr_queue] <= (wr_data[PW-1:0] == rp_nxt[wr_queue]);
          end
          2'd1: begin
            rptr[wr_queue]  <= wr_data[PW-1:0];
            empty[wr_queue] <= (wr_data[PW-1:0] == wptr[wr_queue]);
          end
          2'd2: cfg[wr_queue] <= (cfg[wr_queue] & ~wr_data[19:10]) | (wr_data[9:0] & wr_data[19:10]);
          default: begin
            for (int q = 0; q < NQ; q++)
              if (wr_data[16 + q]) empty[q] <= wr_data[q];
          end
        endcase
      end
    end
  end

  assign rd_wptr     = wptr[rd_queue];
  assign rd_rptr     = rptr[rd_queue];
  assign rd_cfg      = cfg[rd_queue];
  assign empty_flags = empty;
endmodule

// File: rtl/tx_sched_chk.sv
module tx_sched_chk #(
  parameter int NQ  = 16,
  parameter int NCH = 8,
  parameter int PW  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCH-1:0]         chan_en,
  input logic                   wr_en,
  input logic [$clog2(NQ)-1:0]  rd_queue,
  input logic [PW-1:0]          rd_rptr,
  input logic                   req_valid,
  input logic [$clog2(NQ)-1:0]  req_queue,
  input logic [PW-1:0]          req_index,
  input logic [$clog2(NCH)-1:0] req_chan,
  input logic                   req_grant
);
  localparam logic [PW-1:0] ONE = PW'(1);

  a_r1_idle_after_reset: assert property (@(posedge clk) !rst_n |=> !req_valid);

  a_r6_chan_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> (($past(chan_en) >> req_chan) & NCH'(1)) != '0);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_grant) |=> (req_valid && $stable(req_queue) && $stable(req_index) && $stable(req_chan)));

  a_r10_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_grant) |=> !req_valid);

  a_r10_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_grant && !wr_en && rd_queue == req_queue)
      |=> (!$stable(rd_queue) || rd_rptr == $past(rd_rptr) + ONE));
endmodule

bind tx_sched tx_sched_chk #(.NQ(NQ), .NCH(NCH), .PW(PW)) u_chk (.*);

// File: tb/sim_tx_sched.sv
module sim_tx_sched;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [7:0] chan_en = 0;
  logic wr_en = 0;
  logic [1:0] wr_kind = 0;
  logic [3:0] wr_queue = 0, rd_queue = 0;
  logic [31:0] wr_data = 0;
  logic [7:0] rd_wptr, rd_rptr;
  logic [9:0] rd_cfg;
  logic [15:0] empty_flags;
  logic req_valid, req_grant = 0;
  logic [3:0] req_queue;
  logic [7:0] req_index;
  logic [2:0] req_chan;

  int checks = 0, errors = 0;
  int mw[16], mr[16], mc[16], me[16];
  int mlast = 15;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_sched u0 (.clk(clk), .rst_n(rst_n), .chan_en(chan_en), .wr_en(wr_en), .wr_kind(wr_kind),
    .wr_queue(wr_queue), .wr_data(wr_data), .rd_queue(rd_queue), .rd_wptr(rd_wptr),
    .rd_rptr(rd_rptr), .rd_cfg(rd_cfg), .empty_flags(empty_flags), .req_valid(req_valid),
    .req_queue(req_queue), .req_index(req_index), .req_chan(req_chan), .req_grant(req_grant));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int chn(int q); return (mc[q] >> 1) & 7; endfunction
  function automatic int rank(int c); return (c >= 4) ? 4 : c; endfunction
  function automatic bit elig(int q);
    return (mc[q] & 1) && chan_en[chn(q)] && me[q] == 0;
  endfunction
  function automatic int predict();
    int best = -1;
    for (int q = 0; q < 16; q++) if (elig(q) && rank(chn(q)) > best) best = rank(chn(q));
    for (int k = 1; k <= 16; k++) begin
      int j = (mlast + k) % 16;
      if (elig(j) && rank(chn(j)) == best) return j;
    end
    return -1;
  endfunction

  task automatic hw(input int kind, input int q, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_kind = 2'(kind); wr_queue = 4'(q); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    case (kind)
      0: begin mw[q] = d[7:0]; me[q] = (mw[q] == mr[q]); end
      1: begin mr[q] = d[7:0]; me[q] = (mw[q] == mr[q]); end
      2: mc[q] = (mc[q] & ~int'(d[19:10])) | (int'(d[9:0]) & int'(d[19:10]));
      default: for (int i = 0; i < 16; i++) if (d[16+i]) me[i] = d[i];
    endcase
  endtask

  task automatic readback(input int q);
    rd_queue = 4'(q);
    #1;
    chk("R2 wptr", rd_wptr, mw[q]);
    chk("R3 rptr", rd_rptr, mr[q]);
    chk("R4 cfg", rd_cfg, mc[q]);
    chk("R5 empty", empty_flags, flags());
  endtask

  function automatic int flags();
    int f = 0;
    for (int i = 0; i < 16; i++) if (me[i] != 0) f |= (1 << i);
    return f;
  endfunction

  task automatic grant_one(input int q);
    req_grant = 1;
    @(negedge clk);
    req_grant = 0;
    mr[q] = (mr[q] + 1) & 255;
    me[q] = (mr[q] == mw[q]);
    mlast = q;
    chk("R10 bubble", req_valid, 0);
  endtask

  task automatic serve(input int n);
    for (int i = 0; i < n; i++) begin
      int p;
      @(negedge clk);
      p = predict();
      chk("R6 valid", req_valid, p >= 0);
      if (p >= 0 && req_valid) begin
        chk("R7 R8 queue", req_queue, p);
        chk("R11 index", req_index, mr[p]);
        chk("R11 chan", req_chan, chn(p));
        grant_one(p);
      end
    end
  endtask

  task automatic drain();
    int p;
    @(negedge clk);
    p = predict();
    chan_en = 0;
    chk("R6 valid before drain", req_valid, p >= 0);
    if (p >= 0 && req_valid) begin
      for (int h = 0; h < 3; h++) begin
        @(negedge clk);
        chk("R9 hold valid", req_valid, 1);
        chk("R9 hold queue", req_queue, p);
        chk("R9 hold index", req_index, mr[p]);
      end
      grant_one(p);
    end
    @(negedge clk);
    chk("R6 disabled idle", req_valid, 0);
  endtask

  task automatic clear_cfg();
    for (int q = 0; q < 16; q++) hw(2, q, 32'h000FFC00);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int q = 0; q < 16; q++) begin mw[q] = 0; mr[q] = 0; mc[q] = 0; me[q] = 1; end
    #(CLK_PERIOD * 2 + 2);
    chk("R1 req_valid", req_valid, 0);
    readback(0);
    readback(15);
    rst_n = 1;

    // R5 R6 forced idle suppresses a non-empty ring
    hw(2, 3, 32'h000FFC00 | (2 << 1) | 1);
    hw(1, 3, 2);
    hw(0, 3, 10);
    hw(3, 0, 32'h0008_0008);
    readback(3);
    chan_en = 8'hFF;
    serve(1);
    drain();
    clear_cfg();

    // R10 wrap from 255 to 0
    hw(1, 9, 255);
    hw(0, 9, 0);
    hw(2, 9, 32'h000FFC00 | (1 << 1) | 1);
    chan_en = 8'h02;
    serve(2);
    drain();
    readback(9);
    clear_cfg();

    // R5 full ring: indexes equal, idle forced to 0
    hw(1, 5, 7);
    hw(0, 5, 7);
    hw(3, 0, 32'h0020_0000);
    hw(2, 5, 32'h000FFC00 | (2 << 1) | 1);
    readback(5);
    chan_en = 8'h04;
    serve(3);
    drain();
    readback(5);
    clear_cfg();

    // R7 rank order with mixed channels
    hw(2, 1, 32'h000FFC00 | (0 << 1) | 1); hw(0, 1, 40);
    hw(2, 2, 32'h000FFC00 | (3 << 1) | 1); hw(0, 2, 40);
    hw(2, 6, 32'h000FFC00 | (4 << 1) | 1); hw(0, 6, 40);
    hw(2, 7, 32'h000FFC00 | (6 << 1) | 1); hw(0, 7, 40);
    chan_en = 8'hFF;
    serve(6);
    drain();
    clear_cfg();

    // random rounds, R4 masks partial
    for (int r = 0; r < 30; r++) begin
      for (int q = 0; q < 16; q++) begin
        logic [31:0] d;
        d = {12'd0, 10'($urandom), 10'($urandom)};
        hw(2, q, d);
        if ($urandom % 3 == 0) hw(1, q, $urandom % 256);
        hw(0, q, (mr[q] + ($urandom % 4)) & 255);
      end
      if ($urandom % 2 == 0) hw(3, 0, $urandom);
      readback($urandom % 16);
      chan_en = 8'($urandom) | 8'h01;
      serve(10);
      drain();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule